// File: doc/BRIEF.md
# Tone-Detect Guard Time Qualifier

This block sits behind a tone detector that reports, on every clock, whether a valid dual-tone pair is present and which 4-bit digit code it decodes to. It turns that raw per-sample flag into two active-low qualified outputs. The immediate tone-present output follows the raw flag with one register of delay and no filtering. The qualified data-valid output asserts only after the tone has been present for a programmable on time. It deasserts only after the tone has been absent for a separately programmed release time. Short noise bursts therefore never reach data-valid, and brief dropouts never break it.

A 2-bit time select picks one of three on/release pairs. Two of the pairs are symmetric and one is asymmetric. The fourth code is reserved and forces data-valid inactive. Time is counted in a free-running millisecond tick supplied by the system. A held digit register presents the code that a later readout would return. When the decoded digit changes while tones stay present, with no silent gap, the immediate output emits a short inactive pulse. Data-valid stays asserted throughout, and the held digit takes the new code.

Top module: `tgq_guard_qual`

## Requirements
- R1: `td_n` is registered from `raw_valid` with no guard delay: after a clock edge at which `raw_valid` was 0, `td_n` is 1; after an edge at which `raw_valid` was 1, `td_n` is 0 unless a change pulse (R5) is running.
- R2: `dv_n` falls only after `raw_valid` has been sampled high at the on limit's worth of `ms_tick` pulses with no low sample in between. It rises only after `raw_valid` has been sampled low at the release limit's worth of `ms_tick` pulses with no high sample in between.
- R3: `time_sel` encoding: 2'b01 gives 20 ticks on and 20 release, 2'b10 gives 30 on and 30 release, 2'b11 gives 40 on and 20 release.
- R4: While `time_sel` is 2'b00 (reserved), `dv_n` is held 1 and the guard count is cleared.
- R5: If `raw_valid` is high on two consecutive edges and `digit_in` differs between them, `td_n` goes to 1 after the second edge. It stays 1 until the edge that samples the next `ms_tick` (PULSE_TICKS = 1). `dv_n` does not change because of it.
- R6: A dropout shorter than the release limit restarts the release count when tones return, so later dropouts are timed from zero and `dv_n` stays 0.
- R7: `digit_q` loads `digit_in` at every edge where `raw_valid` is high and data-valid is asserted, or becomes asserted, by that edge. It holds its value at all other times, including during dropouts and the gapless change of R5.
- R8: Reset (`rst_n` low, asynchronous) sets `td_n` = 1, `dv_n` = 1 and `digit_q` = 0.
- R9: `td_n` and `dv_n` are active low: 0 means tone present or qualified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| raw_valid | input | 1 | Raw tone-present flag from the detector |
| digit_in | input | DIG_W (4) | Decoded digit code from the detector |
| time_sel | input | 2 | On/release guard time select |
| td_n | output | 1 | Immediate tone-detect, active low |
| dv_n | output | 1 | Guard-qualified data-valid, active low |
| digit_q | output | DIG_W (4) | Held digit code |

## Verification
The checker watches several properties on every clock. It confirms that an absent tone always leaves `td_n` high on the next cycle and that the reserved select code always leaves `dv_n` high. It confirms that `dv_n` only falls after a present sample and only rises after an absent one. It also confirms that the held digit never moves while data-valid is inactive. The exact guard durations for each select code, the restart of the release count after a short dropout, and the width of the gapless-change pulse depend on tick counting across many cycles. Only the bench can show these, by comparing against its behavioural model on every clock and by timed scenario checks.

// File: rtl/tgq_pkg.sv
package tgq_pkg;

   typedef enum logic [1:0] {
      TSEL_RSVD = 2'b00,
      TSEL_A    = 2'b01,
      TSEL_B    = 2'b10,
      TSEL_C    = 2'b11
   } tgq_sel_e;

   function automatic int tgq_max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int tgq_max6(input int a, input int b, input int c,
                                   input int d, input int e, input int f);
      return tgq_max2(tgq_max2(tgq_max2(a, b), tgq_max2(c, d)), tgq_max2(e, f));
   endfunction

endpackage

// File: rtl/tgq_sel_decode.sv
module tgq_sel_decode
   import tgq_pkg::*;
#(
   parameter int CNT_W   = 6,
   parameter int ON_A    = 20,
   parameter int OFF_A   = 20,
   parameter int ON_B    = 30,
   parameter int OFF_B   = 30,
   parameter int ON_C    = 40,
   parameter int OFF_C   = 20
) (
   input  logic [1:0]       time_sel,
   output logic [CNT_W-1:0] on_lim,
   output logic [CNT_W-1:0] off_lim,
   output logic             qual_en
);

   localparam logic [CNT_W-1:0] L_ON_A  = CNT_W'(ON_A);
   localparam logic [CNT_W-1:0] L_OFF_A = CNT_W'(OFF_A);
   localparam logic [CNT_W-1:0] L_ON_B  = CNT_W'(ON_B);
   localparam logic [CNT_W-1:0] L_OFF_B = CNT_W'(OFF_B);
   localparam logic [CNT_W-1:0] L_ON_C  = CNT_W'(ON_C);
   localparam logic [CNT_W-1:0] L_OFF_C = CNT_W'(OFF_C);

   tgq_sel_e sel_e;
   assign sel_e = tgq_sel_e'(time_sel);

   always_comb begin
      on_lim  = '0;
      off_lim = '0;
      qual_en = 1'b0;
      unique case (sel_e)
         TSEL_A: begin on_lim = L_ON_A; off_lim = L_OFF_A; qual_en = 1'b1; end
         TSEL_B: begin on_lim = L_ON_B; off_lim = L_OFF_B; qual_en = 1'b1; end
         TSEL_C: begin on_lim = L_ON_C; off_lim = L_OFF_C; qual_en = 1'b1; end
         default: begin on_lim = '0; off_lim = '0; qual_en = 1'b0; end
      endcase
   end

endmodule

// File: rtl/tgq_guard_timer.sv
module tgq_guard_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             raw_valid,
   input  logic             qual_en,
   input  logic [CNT_W-1:0] on_lim,
   input  logic [CNT_W-1:0] off_lim,
   output logic             dv_on,
   output logic             dv_on_nxt
);

   logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_inc;
   logic             hit;

   assign cnt_inc = cnt_q + 1'b1;
   assign hit     = ms_tick && (cnt_inc >= (dv_on ? off_lim : on_lim));

   always_comb begin
      cnt_nxt   = cnt_q;
      dv_on_nxt = dv_on;
      if (!qual_en) begin
         cnt_nxt   = '0;
         dv_on_nxt = 1'b0;
      end else if (dv_on == raw_valid) begin
         // state agrees with the input: nothing to time
         cnt_nxt = '0;
      end else if (ms_tick) begin
         if (hit) begin
            cnt_nxt   = '0;
            dv_on_nxt = raw_valid;
         end else begin
            cnt_nxt = cnt_inc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dv_on <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         dv_on <= dv_on_nxt;
      end
   end

endmodule

// File: rtl/tgq_change_pulse.sv
module tgq_change_pulse #(
   parameter int DIG_W       = 4,
   parameter int PULSE_TICKS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             raw_valid,
   input  logic [DIG_W-1:0] digit_in,
   output logic             td_n
);

   localparam int PW = (PULSE_TICKS < 1) ? 1 : $clog2(PULSE_TICKS + 1);

   logic             prev_v;
   logic [DIG_W-1:0] prev_d;
   logic             chg;
   logic             pulse_nxt;

   assign chg = raw_valid && prev_v && (digit_in != prev_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_v <= 1'b0;
         prev_d <= '0;
      end else begin
         prev_v <= raw_valid;
         prev_d <= digit_in;
      end
   end

   generate
      if (PULSE_TICKS == 0) begin : g_single_clk
         assign pulse_nxt = chg;
      end else begin : g_tick_count
         logic [PW-1:0] pcnt_q, pcnt_nxt;
         always_comb begin
            pcnt_nxt = pcnt_q;
            if (!raw_valid)                pcnt_nxt = '0;
            else if (chg)                  pcnt_nxt = PW'(PULSE_TICKS);
            else if (ms_tick && pcnt_q != '0) pcnt_nxt = pcnt_q - 1'b1;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pcnt_q <= '0;
            else        pcnt_q <= pcnt_nxt;
         end
         assign pulse_nxt = (pcnt_nxt != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) td_n <= 1'b1;
      else        td_n <= !raw_valid || pulse_nxt;
   end

endmodule

// File: rtl/tgq_guard_qual.sv
module tgq_guard_qual
   import tgq_pkg::*;
#(
   parameter int DIG_W       = 4,
   parameter int PULSE_TICKS = 1,
   parameter int ON_A        = 20,
   parameter int OFF_A       = 20,
   parameter int ON_B        = 30,
   parameter int OFF_B       = 30,
   parameter int ON_C        = 40,
   parameter int OFF_C       = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             raw_valid,
   input  logic [DIG_W-1:0] digit_in,
   input  logic [1:0]       time_sel,
   output logic             td_n,
   output logic             dv_n,
   output logic [DIG_W-1:0] digit_q
);

   localparam int MAX_LIM = tgq_max6(ON_A, OFF_A, ON_B, OFF_B, ON_C, OFF_C);
   localparam int CNT_W   = $clog2(MAX_LIM + 1);

   generate
      if (DIG_W < 1) begin : g_bad_dig
         $error("tgq_guard_qual: DIG_W must be at least 1");
      end
      if (PULSE_TICKS < 0) begin : g_bad_pulse
         $error("tgq_guard_qual: PULSE_TICKS must not be negative");
      end
      if (ON_A < 1 || OFF_A < 1 || ON_B < 1 || OFF_B < 1 || ON_C < 1 || OFF_C < 1)
      begin : g_bad_lim
         $error("tgq_guard_qual: every guard limit must be at least one tick");
      end
   endgenerate

   logic [CNT_W-1:0] on_lim, off_lim;
   logic             qual_en;
   logic             dv_on, dv_on_nxt;

   tgq_sel_decode #(
      .CNT_W(CNT_W),
      .ON_A(ON_A), .OFF_A(OFF_A),
      .ON_B(ON_B), .OFF_B(OFF_B),
      .ON_C(ON_C), .OFF_C(OFF_C)
   ) u_sel (
      .time_sel(time_sel),
      .on_lim  (on_lim),
      .off_lim (off_lim),
      .qual_en (qual_en)
   );

   tgq_guard_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ms_tick  (ms_tick),
      .raw_valid(raw_valid),
      .qual_en  (qual_en),
      .on_lim   (on_lim),
      .off_lim  (off_lim),
      .dv_on    (dv_on),
      .dv_on_nxt(dv_on_nxt)
   );

   tgq_change_pulse #(
      .DIG_W      (DIG_W),
      .PULSE_TICKS(PULSE_TICKS)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .ms_tick  (ms_tick),
      .raw_valid(raw_valid),
      .digit_in (digit_in),
      .td_n     (td_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      digit_q <= '0;
      else if (dv_on_nxt && raw_valid) digit_q <= digit_in;
   end

   assign dv_n = !dv_on;

endmodule

// File: rtl/tgq_guard_qual_chk.sv
module tgq_guard_qual_chk #(
   parameter int DIG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             raw_valid,
   input logic [1:0]       time_sel,
   input logic             td_n,
   input logic             dv_n,
   input logic [DIG_W-1:0] digit_q
);

   // R1
   absent_sets_td_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_valid |=> td_n);

   // R4
   reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (time_sel == 2'b00) |=> dv_n);

   // R2
   dv_fall_needs_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dv_n) |-> $past(raw_valid));

   // R2
   dv_rise_needs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dv_n) && $past(time_sel) != 2'b00) |-> !$past(raw_valid));

   // R7
   digit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dv_n |-> $stable(digit_q));

endmodule

bind tgq_guard_qual tgq_guard_qual_chk #(.DIG_W(DIG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .raw_valid(raw_valid),
   .time_sel (time_sel),
   .td_n     (td_n),
   .dv_n     (dv_n),
   .digit_q  (digit_q)
);

// File: tb/tgq_guard_qual_bench.sv
`timescale 1ns/1ps
module tgq_guard_qual_bench;

   localparam int TICK_DIV = 4;
   localparam int PT       = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic       raw_valid = 1'b0;
   logic [3:0] digit_in = 4'h0;
   logic [1:0] time_sel = 2'b01;
   logic       td_n, dv_n;
   logic [3:0] digit_q;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   int tdiv  = 0;

   tgq_guard_qual u_tgq_guard_qual (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .raw_valid(raw_valid),
      .digit_in(digit_in), .time_sel(time_sel),
      .td_n(td_n), .dv_n(dv_n), .digit_q(digit_q)
   );

   always #5 clk = ~clk;

   // millisecond tick: one cycle in every TICK_DIV
   always @(negedge clk) begin
      tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      ms_tick <= (tdiv == TICK_DIV - 1);
   end

   // behavioural reference model
   int  m_dv, m_cnt, m_pulse, m_prev_v, m_prev_d, m_td, m_dig;
   int  on_t, off_t;
   bit  chg;
   initial begin
      m_dv = 0; m_cnt = 0; m_pulse = 0; m_prev_v = 0; m_prev_d = 0; m_td = 1; m_dig = 0;
   end

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_dv = 0; m_cnt = 0; m_pulse = 0; m_prev_v = 0; m_prev_d = 0; m_td = 1; m_dig = 0;
      end else begin
         chg = raw_valid && m_prev_v != 0 && int'(digit_in) != m_prev_d;
         if (!raw_valid)                   m_pulse = 0;
         else if (chg)                     m_pulse = PT;
         else if (ms_tick && m_pulse > 0)  m_pulse = m_pulse - 1;
         m_td = (!raw_valid || m_pulse > 0) ? 1 : 0;
         case (time_sel)
            2'b01:   begin on_t = 20; off_t = 20; end
            2'b10:   begin on_t = 30; off_t = 30; end
            2'b11:   begin on_t = 40; off_t = 20; end
            default: begin on_t = 0;  off_t = 0;  end
         endcase
         if (time_sel == 2'b00) begin
            m_dv = 0; m_cnt = 0;
         end else if ((m_dv != 0) == raw_valid) begin
            m_cnt = 0;
         end else if (ms_tick) begin
            m_cnt++;
            if (m_cnt >= (m_dv != 0 ? off_t : on_t)) begin
               m_cnt = 0;
               m_dv  = raw_valid ? 1 : 0;
            end
         end
         if (m_dv != 0 && raw_valid) m_dig = int'(digit_in);
         m_prev_v = raw_valid ? 1 : 0;
         m_prev_d = int'(digit_in);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(td_n == m_td[0], "R1/R5 td_n model", int'(td_n), m_td);
         chk(dv_n == !m_dv[0], "R2/R3 dv_n model", int'(dv_n), 1 - m_dv);
         chk(int'(digit_q) == m_dig, "R7 digit_q model", int'(digit_q), m_dig);
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_ms(input int n);
      wait_cyc(n * TICK_DIV);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      wait_cyc(3);
      chk(td_n == 1'b1, "R8 reset td_n", int'(td_n), 1);
      chk(dv_n == 1'b1, "R8 reset dv_n", int'(dv_n), 1);
      chk(digit_q == 4'h0, "R8 reset digit_q", int'(digit_q), 0);
      rst_n = 1'b1;
      wait_cyc(2);

      // select 01: 20 on / 20 release
      time_sel = 2'b01; digit_in = 4'h5; raw_valid = 1'b1;
      wait_cyc(1);
      chk(td_n == 1'b0, "R1 td_n immediate", int'(td_n), 0);
      wait_ms(15);
      chk(dv_n == 1'b1, "R2 dv_n before on time", int'(dv_n), 1);
      wait_ms(10);
      chk(dv_n == 1'b0, "R3 dv_n after 20 on", int'(dv_n), 0);
      chk(digit_q == 4'h5, "R7 digit captured", int'(digit_q), 5);

      // short dropouts: release count restarts
      raw_valid = 1'b0;
      wait_cyc(1);
      chk(td_n == 1'b1, "R1 td_n released", int'(td_n), 1);
      wait_ms(10);
      raw_valid = 1'b1; wait_ms(5);
      raw_valid = 1'b0; wait_ms(15);
      chk(dv_n == 1'b0, "R6 dv_n held across dropouts", int'(dv_n), 0);
      wait_ms(10);
      chk(dv_n == 1'b1, "R2 dv_n after release", int'(dv_n), 1);
      chk(digit_q == 4'h5, "R7 digit held when idle", int'(digit_q), 5);

      // select 11: 40 on / 20 release, gapless change
      time_sel = 2'b11; digit_in = 4'h9; raw_valid = 1'b1;
      wait_ms(30);
      chk(dv_n == 1'b1, "R3 dv_n not yet at 30 with 40 on", int'(dv_n), 1);
      wait_ms(15);
      chk(dv_n == 1'b0, "R3 dv_n after 40 on", int'(dv_n), 0);
      digit_in = 4'hC;
      wait_cyc(1);
      chk(td_n == 1'b1, "R5 change pulse on td_n", int'(td_n), 1);
      chk(dv_n == 1'b0, "R5 dv_n steady through change", int'(dv_n), 0);
      chk(digit_q == 4'hC, "R7 new digit after gapless change", int'(digit_q), 12);
      wait_ms(2);
      chk(td_n == 1'b0, "R5 change pulse ended", int'(td_n), 0);
      raw_valid = 1'b0;
      wait_ms(15);
      chk(dv_n == 1'b0, "R3 dv_n within 20 release", int'(dv_n), 0);
      wait_ms(10);
      chk(dv_n == 1'b1, "R3 dv_n after 20 release", int'(dv_n), 1);

      // select 10: 30 on / 30 release
      time_sel = 2'b10; digit_in = 4'h3; raw_valid = 1'b1;
      wait_ms(25);
      chk(dv_n == 1'b1, "R3 dv_n before 30 on", int'(dv_n), 1);
      wait_ms(10);
      chk(dv_n == 1'b0, "R3 dv_n after 30 on", int'(dv_n), 0);
      raw_valid = 1'b0;
      wait_ms(25);
      chk(dv_n == 1'b0, "R3 dv_n within 30 release", int'(dv_n), 0);
      wait_ms(10);
      chk(dv_n == 1'b1, "R3 dv_n after 30 release", int'(dv_n), 1);

      // reserved select: DV never asserts, digit held
      time_sel = 2'b00; digit_in = 4'hA; raw_valid = 1'b1;
      wait_ms(60);
      chk(dv_n == 1'b1, "R4 reserved select keeps dv_n high", int'(dv_n), 1);
      chk(td_n == 1'b0, "R9 td_n active low while present", int'(td_n), 0);
      chk(digit_q == 4'h3, "R4 digit unchanged under reserved select", int'(digit_q), 3);
      raw_valid = 1'b0;
      wait_ms(2);
      finish_run();
   end

   initial begin
      wait_cyc(100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

endmodule